// File: doc/BRIEF.md
# Link Monitor with Latching Status

This block watches two live indications from the receive front end: whether the receive clock recovery loop holds lock, and whether a receive signal is present. Both inputs are asynchronous. They first pass through a synchronizer chain. The block then derives a lock error and a link fault. A link fault is raised when either lock or signal presence is missing.

Three management-visible status bits hold the history of those conditions between reads:

- In the basic status register, the link-up bit latches low.
- In the detailed status register, the link-up bit latches low.
- In the detailed status register, the lock-error bit latches high.

A management agent pulses one read strobe per register. During the strobe cycle it sees the latched value. On the following clock edge, every bit in that register re-arms to the live condition. The other register is left unchanged.

Top module: `lnkmon_top`

## Requirements
- R1: While `rst_n` is low, all three status outputs are 0. Both link bits and the lock-error bit come out of reset as 0.
- R2: Each input passes through SYNC_STAGES flops (default 2) before use. A change driven between clock edges first shows on the status outputs after the third rising edge, and not after the second.
- R3: `dtl_lock_err_o` goes to 1 after any cycle in which synchronized lock is 0. It then stays 1 until a detailed-register read, even if lock returns.
- R4: A link fault exists when synchronized lock is 0 or synchronized signal-detect is 0. Either cause drives both `std_link_o` and `dtl_link_o` to 0.
- R5: Once 0, each link bit stays 0 until its own register is read, even after the fault clears.
- R6: During the cycle in which a read strobe is high, the outputs of that register show the latched value. After that clock edge, they equal the live condition: link = lock AND signal-detect, and lock error = NOT lock.
- R7: `rd_std_i` affects only `std_link_o`. `rd_dtl_i` affects only `dtl_link_o` and `dtl_lock_err_o`.
- R8: One `rd_dtl_i` pulse re-arms both detailed bits in the same cycle.
- R9: A fault lasting a single clock cycle at the inputs is still captured by the latched bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock_i | input | 1 | Recovery loop lock indication (asynchronous) |
| sig_det_i | input | 1 | Receive signal present (asynchronous) |
| rd_std_i | input | 1 | Single-cycle read strobe for the basic status register |
| rd_dtl_i | input | 1 | Single-cycle read strobe for the detailed status register |
| std_link_o | output | 1 | Latch-low link-up bit, basic register |
| dtl_link_o | output | 1 | Latch-low link-up bit, detailed register |
| dtl_lock_err_o | output | 1 | Latch-high lock-error bit, detailed register |

## Verification
The assertions assume that each read strobe is a clean synchronous pulse. They also assume that any input level worth capturing is held across at least one rising edge. The synchronizer can only sample at edges, so a shorter glitch may never be seen.

The bench changes inputs only on falling edges and holds each level for a whole cycle or longer. It sweeps every ordered pair of the four lock/signal-detect combinations, with reads of one or both registers in between. It then adds a single-cycle fault pulse and a latency probe that samples on either side of the expected edge.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;
  typedef enum logic {
    LATCH_LOW  = 1'b0,
    LATCH_HIGH = 1'b1
  } latch_kind_e;
endpackage

// File: rtl/lnkmon_sync.sv
module lnkmon_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] chain_d;
    if (s == 0) begin : g_first
      assign chain_d = async_i;
    end else begin : g_next
      assign chain_d = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lnkmon_latch.sv
module lnkmon_latch #(
  parameter lnkmon_pkg::latch_kind_e KIND = lnkmon_pkg::LATCH_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic rearm_i,
  output logic held_o
);
  logic held_q, held_d, upd_en, merged;

  if (KIND == lnkmon_pkg::LATCH_HIGH) begin : g_hi
    assign merged = held_q | live_i;
  end else begin : g_lo
    assign merged = held_q & live_i;
  end

  always_comb begin
    held_d = rearm_i ? live_i : merged;
    upd_en = rearm_i | (held_d != held_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= 1'b0;
    else if (upd_en) held_q <= held_d;
  end

  assign held_o = held_q;
endmodule

// File: rtl/lnkmon_top.sv
module lnkmon_top #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_lock_i,
  input  logic sig_det_i,
  input  logic rd_std_i,
  input  logic rd_dtl_i,
  output logic std_link_o,
  output logic dtl_link_o,
  output logic dtl_lock_err_o
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_in, sync_in;
  logic lock_live, sd_live, err_live, link_live;

  assign raw_in = {pll_lock_i, sig_det_i};

  lnkmon_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(sync_in)
  );

  assign lock_live = sync_in[1];
  assign sd_live   = sync_in[0];
  assign err_live  = ~lock_live;
  assign link_live = lock_live & sd_live;

  lnkmon_latch #(.KIND(lnkmon_pkg::LATCH_LOW)) u_std_link (
    .clk(clk), .rst_n(rst_n), .live_i(link_live), .rearm_i(rd_std_i),
    .held_o(std_link_o)
  );

  lnkmon_latch #(.KIND(lnkmon_pkg::LATCH_LOW)) u_dtl_link (
    .clk(clk), .rst_n(rst_n), .live_i(link_live), .rearm_i(rd_dtl_i),
    .held_o(dtl_link_o)
  );

  lnkmon_latch #(.KIND(lnkmon_pkg::LATCH_HIGH)) u_dtl_err (
    .clk(clk), .rst_n(rst_n), .live_i(err_live), .rearm_i(rd_dtl_i),
    .held_o(dtl_lock_err_o)
  );
endmodule

// File: rtl/lnkmon_chk.sv
module lnkmon_chk (
  input logic clk,
  input logic rst_n,
  input logic pll_lock_i,
  input logic rd_std_i,
  input logic rd_dtl_i,
  input logic lock_live,
  input logic link_live,
  input logic std_link_o,
  input logic dtl_link_o,
  input logic dtl_lock_err_o
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2: live lock trails the pin by exactly two edges
  p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (lock_live == $past(pll_lock_i, 2)));

  // R3: lock loss sets the error bit
  p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_live |=> dtl_lock_err_o);

  // R3: error holds without a detailed read
  p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dtl_lock_err_o && !rd_dtl_i) |=> dtl_lock_err_o);

  // R4: a fault clears both link bits
  p_fault_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !link_live |=> (!std_link_o && !dtl_link_o));

  // R5: a low link bit holds without its own read
  p_std_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!std_link_o && !rd_std_i) |=> !std_link_o);

  p_dtl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtl_link_o && !rd_dtl_i) |=> !dtl_link_o);

  // R6: a read re-arms to the live condition
  p_std_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_std_i |=> (std_link_o == $past(link_live)));

  // R8: a detailed read re-arms both detailed bits together
  p_dtl_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dtl_i |=> ((dtl_link_o == $past(link_live)) &&
                  (dtl_lock_err_o == !$past(lock_live))));

  // R7: a basic read alone leaves the detailed bits unchanged while the link is live
  p_indep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_std_i && !rd_dtl_i && link_live) |=> $stable(dtl_link_o));
endmodule

bind lnkmon_top lnkmon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_lock_i(pll_lock_i),
  .rd_std_i(rd_std_i), .rd_dtl_i(rd_dtl_i),
  .lock_live(lock_live), .link_live(link_live),
  .std_link_o(std_link_o), .dtl_link_o(dtl_link_o),
  .dtl_lock_err_o(dtl_lock_err_o)
);

// File: tb/lnkmon_top_tb.sv
module lnkmon_top_tb;
  logic clk, rst_n, pll_lock_i, sig_det_i, rd_std_i, rd_dtl_i;
  logic std_link_o, dtl_link_o, dtl_lock_err_o;
  int n_chk, n_bad;
  bit done;

  lnkmon_top u_dut (
    .clk(clk), .rst_n(rst_n), .pll_lock_i(pll_lock_i), .sig_det_i(sig_det_i),
    .rd_std_i(rd_std_i), .rd_dtl_i(rd_dtl_i), .std_link_o(std_link_o),
    .dtl_link_o(dtl_link_o), .dtl_lock_err_o(dtl_lock_err_o)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle strobe; outputs checked while strobe is high (R6: latched view)
  task automatic do_read(bit s, bit d, logic e_std, logic e_dl, logic e_err);
    rd_std_i = s; rd_dtl_i = d;
    chk("R6 std latched view", std_link_o, e_std);
    chk("R6 dtl link latched view", dtl_link_o, e_dl);
    chk("R6 err latched view", dtl_lock_err_o, e_err);
    tick(1);
    rd_std_i = 0; rd_dtl_i = 0;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ea, eb, la, lb;
    rst_n = 0; pll_lock_i = 1; sig_det_i = 1; rd_std_i = 0; rd_dtl_i = 0;
    tick(3);
    chk("R1 std reset", std_link_o, 1'b0);
    chk("R1 dtl reset", dtl_link_o, 1'b0);
    chk("R1 err reset", dtl_lock_err_o, 1'b0);
    rst_n = 1;
    tick(5);
    rd_std_i = 1; rd_dtl_i = 1; tick(1); rd_std_i = 0; rd_dtl_i = 0;
    chk("R6 std after clear", std_link_o, 1'b1);
    chk("R6 err after clear", dtl_lock_err_o, 1'b0);

    // R2 latency probe
    pll_lock_i = 0;
    tick(2);
    chk("R2 not yet after two edges", dtl_lock_err_o, 1'b0);
    tick(1);
    chk("R2 seen after third edge", dtl_lock_err_o, 1'b1);
    pll_lock_i = 1; tick(4);
    chk("R3 error held after lock returns", dtl_lock_err_o, 1'b1);
    chk("R5 link held low after recovery", std_link_o, 1'b0);
    do_read(1, 1, 1'b0, 1'b0, 1'b1);

    // sweep all ordered pairs of input states
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        la = (a == 3); ea = (a < 2);
        lb = (b == 3); eb = (b < 2);
        pll_lock_i = a[1]; sig_det_i = a[0];
        tick(4);
        rd_std_i = 1; rd_dtl_i = 1; tick(1); rd_std_i = 0; rd_dtl_i = 0;
        chk("R6 std rearm", std_link_o, la);
        chk("R8 err rearm", dtl_lock_err_o, ea);
        chk("R8 dtl rearm", dtl_link_o, la);
        pll_lock_i = b[1]; sig_det_i = b[0];
        tick(4);
        chk("R3 err accumulates", dtl_lock_err_o, ea | eb);
        chk("R4 std fault", std_link_o, la & lb);
        chk("R5 dtl latched low", dtl_link_o, la & lb);
        do_read(1, 0, la & lb, la & lb, ea | eb);
        chk("R6 std live after read", std_link_o, lb);
        chk("R7 dtl link untouched", dtl_link_o, la & lb);
        chk("R7 err untouched", dtl_lock_err_o, ea | eb);
        do_read(0, 1, lb, la & lb, ea | eb);
        chk("R8 err live", dtl_lock_err_o, eb);
        chk("R8 dtl link live", dtl_link_o, lb);
        chk("R7 std untouched", std_link_o, lb);
      end
    end

    // R9 single-cycle fault pulse
    pll_lock_i = 1; sig_det_i = 1; tick(4);
    do_read(1, 1, 1'b1, 1'b1, 1'b0);
    sig_det_i = 0; tick(1); sig_det_i = 1; tick(5);
    chk("R9 std captured pulse", std_link_o, 1'b0);
    chk("R9 dtl captured pulse", dtl_link_o, 1'b0);
    chk("R9 err unaffected", dtl_lock_err_o, 1'b0);
    pll_lock_i = 0; tick(1); pll_lock_i = 1; tick(5);
    chk("R9 err captured pulse", dtl_lock_err_o, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule